// File: doc/BRIEF.md
# Selectless Master/Slave Serial Shift Port

This block is a byte-wide synchronous serial port with no chip-select input. Each transfer sends one byte out on a data-out line and takes one byte in from a data-in line. A serial clock times the transfer. The serial clock rests high between transfers. A transfer starts at the first falling edge of that clock and ends at the eighth rising edge. No framing signal is involved.

Software picks master or slave mode with a control bit. The two modes differ only in where the serial clock comes from. In master mode the port divides its internal clock by 2, 4, 16 or 32 and drives the clock pin. In slave mode the clock comes from outside the port. The port passes it through a two-flop synchroniser and then detects its edges.

A small register interface controls the port. Address 0 is the control register: bit 0 enables the port, bit 1 selects master mode and bits 3:2 select the rate. Address 1 is the status register: bit 7 is the transfer-complete flag and bit 6 is the write-collision flag. Address 2 is the data register, which loads and reads the shift register.

Top module: `ssp_port`

## Requirements
- R1: After reset the control and status registers read 0. sck_out is high, sck_oe is low and sdo is low.
- R2: In master mode a data write at clock edge W makes sck_out toggle at edges W+k·H for k = 1..16, so it gives eight low pulses and then rests high. H is 1, 2, 8 or 16 for rate codes 0, 1, 2 and 3, which is a divide of 2, 4, 16 or 32. sck_out is high whenever no transfer is active.
- R3: Data leaves MSB first. Bit 7 of the written byte is on sdo right after the write, before the first falling edge. Each later bit replaces it after a falling serial-clock edge.
- R4: sdi is sampled on each rising serial-clock edge and shifted in MSB first. After the transfer, a data read returns the received byte.
- R5: The eighth rising edge sets status bit 7 (transfer complete) and ends the transfer.
- R6: Status bits 7 and 6 clear only when a status read that saw bit 7 set is followed by an access to the data register. A data access without that prior status read leaves them set.
- R7: A data write during an active transfer is ignored. The byte being sent and the byte received are unaffected, and status bit 6 (write collision) is set.
- R8: In slave mode sck_oe is low and the shift timing follows sck_in after two-flop synchronisation: a transfer starts at the first synchronised falling edge, sdo is updated after each falling edge, and status bit 7 is set after the eighth rising edge.
- R9: A data write while the port is disabled, or in slave mode, produces no serial clock. sck_out stays high.
- R10: The control register reads back the enable, master and rate fields as written: bit 0 enable, bit 1 master, bits 3:2 rate.
- R11: Clearing the enable bit during a master transfer stops it immediately. sck_out returns high and status bit 7 is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered one cycle after reg_rd |
| sck_in | input | 1 | External serial clock, used in slave mode |
| sdi | input | 1 | Serial data in |
| sck_out | output | 1 | Serial clock driven in master mode, high otherwise |
| sck_oe | output | 1 | High when the port drives the serial clock |
| sdo | output | 1 | Serial data out |

## Verification
Master transfers run at all four rates, each with a different pair of transmit and receive bytes. A reference model compares the serial clock every cycle, so a wrong divide ratio or a wrong edge count shows up as a clock mismatch. Bytes with asymmetric bit patterns separate MSB-first from LSB-first order and show whether sampling happens at the right edge. A slave transfer driven by a slow external clock checks the synchroniser path separately from the master clock path. Further runs cover the collision write, the two-step flag clear with and without its status read, an abort by disabling the port, and writes made while disabled or in slave mode.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef logic [1:0] rate_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // Half period of the master serial clock, in internal clock cycles.
  function automatic int unsigned half_div(rate_t r);
    case (r)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int unsigned XFER_BITS = 8,
  parameter int unsigned HALF_W    = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       start,
  input  logic [1:0] rate,
  output logic       sck,
  output logic       rise_p,
  output logic       fall_p,
  output logic       running
);
  localparam int unsigned EDGE_W = $clog2(2 * XFER_BITS);

  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] half_lim;
  logic [EDGE_W-1:0] edges;
  logic [1:0]        rate_q;

  assign half_lim = HALF_W'(ssp_pkg::half_div(rate_q) - 1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      running <= 1'b0;
      sck     <= 1'b1;
      cnt     <= '0;
      edges   <= '0;
      rise_p  <= 1'b0;
      fall_p  <= 1'b0;
      rate_q  <= '0;
    end else begin
      rise_p <= 1'b0;
      fall_p <= 1'b0;
      if (start && !running) begin
        running <= 1'b1;
        cnt     <= '0;
        edges   <= '0;
        sck     <= 1'b1;
        rate_q  <= rate;
      end else if (running) begin
        if (cnt == half_lim) begin
          cnt <= '0;
          sck <= ~sck;
          if (sck) fall_p <= 1'b1;
          else     rise_p <= 1'b1;
          edges <= edges + 1'b1;
          if (edges == EDGE_W'(2 * XFER_BITS - 1)) running <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_GEN_ENDS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> sck); // R2
endmodule

// File: rtl/ssp_sync.sv
module ssp_sync (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= sck_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  AST_SYNC_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R8
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned XFER_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 load,
  input  logic [XFER_BITS-1:0] ldata,
  input  logic                 go,
  input  logic                 slave,
  input  logic                 rise_ev,
  input  logic                 fall_ev,
  input  logic                 sdi,
  output logic [XFER_BITS-1:0] sr,
  output logic                 sdo,
  output logic                 active,
  output logic                 finish
);
  localparam int unsigned CW = $clog2(XFER_BITS);

  logic [CW-1:0] cnt;

  assign finish = active && rise_ev && (cnt == CW'(XFER_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      sdo    <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else if (!en) begin
      active <= 1'b0;
      cnt    <= '0;
      if (load) begin
        sr  <= ldata;
        sdo <= ldata[XFER_BITS-1];
      end
    end else if (load) begin
      sr     <= ldata;
      sdo    <= ldata[XFER_BITS-1];
      cnt    <= '0;
      active <= go;
    end else begin
      if (fall_ev && (active || slave)) begin
        active <= 1'b1;
        sdo    <= sr[XFER_BITS-1];
      end
      if (rise_ev && active) begin
        sr <= {sr[XFER_BITS-2:0], sdi};
        if (finish) begin
          active <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !active |-> (cnt == '0)); // R5
endmodule

// File: rtl/ssp_port.sv
module ssp_port #(
  parameter int unsigned XFER_BITS = 8,
  parameter int unsigned HALF_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [1:0]           reg_addr,
  input  logic [XFER_BITS-1:0] reg_wdata,
  output logic [XFER_BITS-1:0] reg_rdata,
  input  logic                 sck_in,
  input  logic                 sdi,
  output logic                 sck_out,
  output logic                 sck_oe,
  output logic                 sdo
);
  import ssp_pkg::*;

  logic       en_q, mst_q;
  logic [1:0] rate_q;
  logic       done_q, wcol_q, armed_q;

  logic gen_sck, gen_rise, gen_fall, gen_run;
  logic syn_rise, syn_fall;
  logic rise_ev, fall_ev;
  logic sh_active, sh_finish;
  logic [XFER_BITS-1:0] sh_data;

  logic data_wr, data_acc, load, collide, go, clr;

  assign data_wr  = reg_wr && (reg_addr == ADDR_DATA);
  assign data_acc = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);
  assign load     = data_wr && !sh_active;
  assign collide  = data_wr && sh_active;
  assign go       = load && en_q && mst_q;
  assign clr      = armed_q && data_acc;

  assign rise_ev = mst_q ? gen_rise : syn_rise;
  assign fall_ev = mst_q ? gen_fall : syn_fall;

  ssp_clkgen #(.XFER_BITS(XFER_BITS), .HALF_W(HALF_W)) u_clkgen (
    .clk(clk), .rst(rst), .en(en_q && mst_q), .start(go), .rate(rate_q),
    .sck(gen_sck), .rise_p(gen_rise), .fall_p(gen_fall), .running(gen_run)
  );

  ssp_sync u_sync (
    .clk(clk), .rst(rst), .sck_in(sck_in), .rise(syn_rise), .fall(syn_fall)
  );

  ssp_shifter #(.XFER_BITS(XFER_BITS)) u_shifter (
    .clk(clk), .rst(rst), .en(en_q), .load(load), .ldata(reg_wdata),
    .go(go), .slave(!mst_q), .rise_ev(rise_ev), .fall_ev(fall_ev), .sdi(sdi),
    .sr(sh_data), .sdo(sdo), .active(sh_active), .finish(sh_finish)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mst_q  <= 1'b0;
      rate_q <= '0;
    end else if (reg_wr && (reg_addr == ADDR_CTRL)) begin
      en_q   <= reg_wdata[0];
      mst_q  <= reg_wdata[1];
      rate_q <= reg_wdata[3:2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      wcol_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (sh_finish)  done_q <= 1'b1;
      else if (clr)   done_q <= 1'b0;
      if (collide)    wcol_q <= 1'b1;
      else if (clr)   wcol_q <= 1'b0;
      if (clr)
        armed_q <= 1'b0;
      else if (reg_rd && (reg_addr == ADDR_STAT) && done_q)
        armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADDR_CTRL: reg_rdata <= XFER_BITS'({rate_q, mst_q, en_q});
        ADDR_STAT: reg_rdata <= {done_q, wcol_q, {(XFER_BITS-2){1'b0}}};
        ADDR_DATA: reg_rdata <= sh_data;
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assign sck_oe  = en_q && mst_q;
  assign sck_out = sck_oe ? gen_sck : 1'b1;

  AST_SCK_REST_HIGH: assert property (@(posedge clk) disable iff (rst)
    !sh_active |-> sck_out); // R2
  AST_DONE_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(rise_ev)); // R5
  AST_WCOL_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(wcol_q) |-> $past(sh_active)); // R7
  AST_SLAVE_NO_GEN: assert property (@(posedge clk) disable iff (rst)
    !mst_q |-> !gen_run); // R9
endmodule

// File: tb/test_ssp_port.sv
module test_ssp_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sck_in = 1'b1, sdi = 1'b0;
  logic       sck_out, sck_oe, sdo;

  int checks = 0, failures = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  ssp_port i_ssp_port (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_in(sck_in), .sdi(sdi),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdo(sdo)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference for the serial clock (R2, R9, R11)
  bit m_en = 0, m_mst = 0, m_act = 0, m_sck = 1;
  int m_h = 1, m_tick = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_mst = 0; m_act = 0; m_sck = 1; m_h = 1;
    end else begin
      if (m_act) begin
        m_tick++;
        if (m_tick % m_h == 0) m_sck = ~m_sck;
        if (m_tick == 16 * m_h) m_act = 0;
      end else if (reg_wr && reg_addr == 2 && m_en && m_mst) begin
        m_act = 1; m_tick = 0; m_sck = 1;
      end
      if (reg_wr && reg_addr == 0) begin
        m_en = reg_wdata[0]; m_mst = reg_wdata[1];
        case (reg_wdata[3:2]) 0: m_h = 1; 1: m_h = 2; 2: m_h = 8; default: m_h = 16; endcase
        if (!reg_wdata[0] || !reg_wdata[1]) begin m_act = 0; m_sck = 1; end
      end
    end
  end

  always @(negedge clk) if (!rst && !done_flag) chk("R2 sck_out vs model", sck_out, m_sck);

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic master_xfer(int rate, logic [7:0] tx, logic [7:0] rx, int collide_at);
    logic prev = 1;
    int rises = 0, falls = 0, guard = 0;
    logic [7:0] got = '0;
    logic [7:0] v;
    wr(0, 8'(3 | (rate << 2)));
    wr(2, tx);
    chk("R3 first bit before first fall", sdo, tx[7]);
    while (rises < 8 && guard < 2000) begin
      @(negedge clk); guard++;
      reg_wr = 0;
      if (prev && !sck_out) begin
        sdi = rx[7 - falls]; falls++;
      end else if (!prev && sck_out) begin
        got[7 - rises] = sdo; rises++;
        if (rises == collide_at) begin reg_wr = 1; reg_addr = 2; reg_wdata = ~tx; end
      end
      prev = sck_out;
    end
    reg_wr = 0;
    chk("R3 sdo MSB first", got, tx);
    repeat (3) @(negedge clk);
    rd(1, v);
    chk("R5/R7 status after master transfer", v, collide_at > 0 ? 8'hC0 : 8'h80);
    rd(2, v);
    chk("R4 received byte", v, rx);
    rd(1, v);
    chk("R6 status cleared", v, 0);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 sck_out reset", sck_out, 1);
    chk("R1 sck_oe reset", sck_oe, 0);
    chk("R1 sdo reset", sdo, 0);
    rd(0, v); chk("R1 ctrl reset", v, 0);
    rd(1, v); chk("R1 status reset", v, 0);

    wr(0, 8'h0E); rd(0, v); chk("R10 ctrl readback", v, 8'h0E);
    wr(0, 8'h05); rd(0, v); chk("R10 ctrl readback 2", v, 8'h05);

    master_xfer(0, 8'hA3, 8'h5C, 0);
    master_xfer(1, 8'h81, 8'h7E, 0);
    master_xfer(2, 8'h1F, 8'hC4, 0);
    master_xfer(3, 8'h6B, 8'h92, 0);
    master_xfer(1, 8'hD2, 8'h35, 3); // R7 collision mid transfer

    // R6: data access without prior status read leaves the flag
    master_xfer(0, 8'h44, 8'h11, 0);
    wr(2, 8'hF0);
    repeat (40) @(negedge clk);
    rd(2, v);
    rd(1, v); chk("R6 no clear without status read", v, 8'h80);
    rd(2, v);
    rd(1, v); chk("R6 clear after status read", v, 0);

    // R11 abort by disable
    wr(0, 8'h0F); wr(2, 8'hAA);
    repeat (40) @(negedge clk);
    wr(0, 8'h0E);
    chk("R11 sck high after disable", sck_out, 1);
    repeat (20) @(negedge clk);
    rd(1, v); chk("R11 no done after abort", v, 0);

    // R9 writes while disabled or in slave mode make no clock
    wr(2, 8'h33);
    repeat (30) @(negedge clk);
    chk("R9 no clock while disabled", sck_out, 1);
    wr(0, 8'h01);
    chk("R8 sck_oe low in slave", sck_oe, 0);
    wr(2, 8'hB6);
    repeat (30) @(negedge clk);
    chk("R9 no clock in slave", sck_out, 1);
    rd(1, v); chk("R9 no done in slave without clock", v, 0);

    // R8 slave transfer on external clock
    chk("R8 first bit before first fall", sdo, 1);
    for (int k = 0; k < 8; k++) begin
      sck_in = 0; sdi = (8'h4D >> (7 - k)) & 1;
      repeat (6) @(negedge clk);
      chk("R8 sdo after fall", sdo, (8'hB6 >> (7 - k)) & 1);
      sck_in = 1;
      repeat (6) @(negedge clk);
    end
    rd(1, v); chk("R8 slave done", v, 8'h80);
    rd(2, v); chk("R8 slave received", v, 8'h4D);
    rd(1, v); chk("R8 slave status cleared", v, 0);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule